// File: doc/BRIEF.md
# Counter-Rotating Ring Stop with Address-Sliced Routing

This block is one stop on a pair of rings that move flits in opposite directions, clockwise and counter-clockwise. A client at the stop presents a request with a physical address and a data word. The stop folds the address into a cache-slice number, so that consecutive lines spread over every slice. It then works out which stop on its own ring must receive the flit, and picks the direction that gets there in fewer hops.

Slices numbered below `NUM_STOPS` sit on this stop's ring, one per stop, at the stop of equal index. Higher-numbered slices sit on the other ring, and flits for them go to the bridge stop, which hands them across. A request for the slice at this very stop never enters a ring. It is delivered on a local port one cycle later. Flits arriving on either ring are either taken off here or forwarded with one register per hop. Traffic already on a ring always wins over a new injection.

Top module: `ringstop`

## Requirements
- R1: The slice number is computed as follows. Bit i of a 4-bit fold is the XOR of every address bit `6+i+4k` (k = 0,1,...) below bit 32. The slice is the fold modulo 12. The slice is carried in flit bits [19:16].
- R2: A slice s below 6 targets stop s. Any other slice targets bridge stop 0. The target stop is carried in flit bits [22:20], and the data word is carried in bits [15:0].
- R3: A non-local request goes clockwise when the clockwise hop count `(dst-2) mod 6` is no larger than the counter-clockwise count `(2-dst) mod 6`. Otherwise it goes counter-clockwise. A tie picks clockwise.
- R4: A request whose target stop is this stop (stop 2) is always accepted. It raises `loc_valid` with its slice and data one cycle later, and it never appears on a ring output.
- R5: An incoming ring flit whose target is not stop 2 leaves on the same ring's output one cycle later, unchanged.
- R6: An incoming ring flit whose target is stop 2 appears on that ring's eject port one cycle later. It is not forwarded.
- R7: While a flit is passing through on the chosen ring, `req_ready` is low and nothing is injected. Once the slot is free, an accepted request appears on the chosen ring's output one cycle later.
- R8: A slot freed by an ejection in the same cycle may take a new injection.
- R9: A cycle with `rst` high clears every output valid on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request present |
| req_addr | input | 32 | Physical address of the request |
| req_data | input | 16 | Data word of the request |
| req_ready | output | 1 | Request accepted this cycle |
| cw_in_valid | input | 1 | Clockwise flit arriving from upstream |
| cw_in_flit | input | 23 | Clockwise incoming flit {dst, slice, data} |
| cw_out_valid | output | 1 | Clockwise flit leaving downstream |
| cw_out_flit | output | 23 | Clockwise outgoing flit |
| ccw_in_valid | input | 1 | Counter-clockwise flit arriving |
| ccw_in_flit | input | 23 | Counter-clockwise incoming flit |
| ccw_out_valid | output | 1 | Counter-clockwise flit leaving |
| ccw_out_flit | output | 23 | Counter-clockwise outgoing flit |
| cw_ej_valid | output | 1 | Flit taken off the clockwise ring |
| cw_ej_flit | output | 23 | Ejected clockwise flit |
| ccw_ej_valid | output | 1 | Flit taken off the counter-clockwise ring |
| ccw_ej_flit | output | 23 | Ejected counter-clockwise flit |
| loc_valid | output | 1 | Local-slice delivery |
| loc_slice | output | 4 | Slice of the local delivery |
| loc_data | output | 16 | Data of the local delivery |

## Verification
`req_ready` is combinational, so it is compared in the same cycle as the inputs that drive it. Every other result comes through exactly one register: a forwarded flit, an ejected flit, an injected flit and a local delivery are all due one cycle after the edge that takes in their stimulus. The bench applies inputs after a falling edge. It checks `req_ready` shortly after that, then checks every registered output just after the next rising edge against a model updated from those same inputs. Directed steps cover the tie, the bridge route, local delivery, blocking by passing traffic and injection into an ejected slot, and a long random run follows.

// File: rtl/ringstop_pkg.sv
package ringstop_pkg;
  typedef enum logic {DIR_CW = 1'b0, DIR_CCW = 1'b1} ring_dir_t;
endpackage

// File: rtl/slice_hash.sv
module slice_hash #(
  parameter int HI_W       = 26,
  parameter int NUM_SLICES = 12,
  localparam int FOLD_W    = $clog2(NUM_SLICES),
  localparam int SLICE_W   = $clog2(NUM_SLICES)
) (
  input  logic [HI_W-1:0]    line_addr,
  output logic [SLICE_W-1:0] slice
);
  logic [FOLD_W-1:0] fold;

  always_comb begin
    fold = '0;
    for (int i = 0; i < HI_W; i++)
      fold[i % FOLD_W] = fold[i % FOLD_W] ^ line_addr[i];
    slice = SLICE_W'(int'(fold) % NUM_SLICES);
  end
endmodule

// File: rtl/route_pick.sv
module route_pick
  import ringstop_pkg::*;
#(
  parameter int NUM_STOPS   = 6,
  parameter int NUM_SLICES  = 12,
  parameter int MY_STOP     = 2,
  parameter int MY_RING     = 0,
  parameter int BRIDGE_STOP = 0,
  localparam int STOP_W     = $clog2(NUM_STOPS),
  localparam int SLICE_W    = $clog2(NUM_SLICES)
) (
  input  logic [SLICE_W-1:0] slice,
  output logic [STOP_W-1:0]  dst,
  output logic               is_local,
  output ring_dir_t          dir
);
  int s, d, cw_hops, ccw_hops;

  always_comb begin
    s = int'(slice);
    if (s / NUM_STOPS == MY_RING) d = s % NUM_STOPS;
    else                          d = BRIDGE_STOP;
    cw_hops  = (d - MY_STOP + NUM_STOPS) % NUM_STOPS;
    ccw_hops = (MY_STOP - d + NUM_STOPS) % NUM_STOPS;
    dst      = STOP_W'(d);
    is_local = (d == MY_STOP);
    dir      = (cw_hops <= ccw_hops) ? DIR_CW : DIR_CCW;
  end
endmodule

// File: rtl/ring_lane.sv
module ring_lane #(
  parameter int MY_STOP = 2,
  parameter int STOP_W  = 3,
  parameter int FLIT_W  = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  input  logic              inj_valid,
  input  logic [FLIT_W-1:0] inj_flit,
  output logic              slot_free,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_flit,
  output logic              ej_valid,
  output logic [FLIT_W-1:0] ej_flit
);
  logic here;

  assign here      = (in_flit[FLIT_W-1 -: STOP_W] == STOP_W'(MY_STOP));
  assign slot_free = !in_valid || here;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ej_valid  <= 1'b0;
      out_flit  <= '0;
      ej_flit   <= '0;
    end else begin
      ej_valid <= in_valid && here;
      if (in_valid && here) ej_flit <= in_flit;
      if (in_valid && !here) begin
        out_valid <= 1'b1;
        out_flit  <= in_flit;
      end else if (inj_valid) begin
        out_valid <= 1'b1;
        out_flit  <= inj_flit;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ringstop.sv
module ringstop
  import ringstop_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_OFF    = 6,
  parameter int DATA_W      = 16,
  parameter int NUM_STOPS   = 6,
  parameter int NUM_SLICES  = 12,
  parameter int MY_STOP     = 2,
  parameter int MY_RING     = 0,
  parameter int BRIDGE_STOP = 0,
  localparam int STOP_W     = $clog2(NUM_STOPS),
  localparam int SLICE_W    = $clog2(NUM_SLICES),
  localparam int FLIT_W     = STOP_W + SLICE_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  input  logic              cw_in_valid,
  input  logic [FLIT_W-1:0] cw_in_flit,
  output logic              cw_out_valid,
  output logic [FLIT_W-1:0] cw_out_flit,
  input  logic              ccw_in_valid,
  input  logic [FLIT_W-1:0] ccw_in_flit,
  output logic              ccw_out_valid,
  output logic [FLIT_W-1:0] ccw_out_flit,
  output logic              cw_ej_valid,
  output logic [FLIT_W-1:0] cw_ej_flit,
  output logic              ccw_ej_valid,
  output logic [FLIT_W-1:0] ccw_ej_flit,
  output logic              loc_valid,
  output logic [SLICE_W-1:0] loc_slice,
  output logic [DATA_W-1:0] loc_data
);
  logic [SLICE_W-1:0] slice;
  logic [STOP_W-1:0]  dst;
  logic               is_local;
  ring_dir_t          dir;
  logic [FLIT_W-1:0]  new_flit;

  logic [1:0]        in_v, inj_v, free_v, out_v, ej_v;
  logic [FLIT_W-1:0] in_f  [2];
  logic [FLIT_W-1:0] out_f [2];
  logic [FLIT_W-1:0] ej_f  [2];

  slice_hash #(.HI_W(ADDR_W - LINE_OFF), .NUM_SLICES(NUM_SLICES)) u_hash (
    .line_addr(req_addr[ADDR_W-1:LINE_OFF]),
    .slice    (slice)
  );

  route_pick #(
    .NUM_STOPS(NUM_STOPS), .NUM_SLICES(NUM_SLICES), .MY_STOP(MY_STOP),
    .MY_RING(MY_RING), .BRIDGE_STOP(BRIDGE_STOP)
  ) u_route (
    .slice(slice), .dst(dst), .is_local(is_local), .dir(dir)
  );

  assign new_flit  = {dst, slice, req_data};
  assign req_ready = is_local || free_v[dir];

  assign in_v[DIR_CW]  = cw_in_valid;
  assign in_v[DIR_CCW] = ccw_in_valid;
  assign in_f[DIR_CW]  = cw_in_flit;
  assign in_f[DIR_CCW] = ccw_in_flit;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign inj_v[g] = req_valid && !is_local && (int'(dir) == g) && free_v[g];
    ring_lane #(.MY_STOP(MY_STOP), .STOP_W(STOP_W), .FLIT_W(FLIT_W)) u_lane (
      .clk(clk), .rst(rst),
      .in_valid(in_v[g]), .in_flit(in_f[g]),
      .inj_valid(inj_v[g]), .inj_flit(new_flit),
      .slot_free(free_v[g]),
      .out_valid(out_v[g]), .out_flit(out_f[g]),
      .ej_valid(ej_v[g]), .ej_flit(ej_f[g])
    );
  end

  assign cw_out_valid  = out_v[DIR_CW];
  assign cw_out_flit   = out_f[DIR_CW];
  assign ccw_out_valid = out_v[DIR_CCW];
  assign ccw_out_flit  = out_f[DIR_CCW];
  assign cw_ej_valid   = ej_v[DIR_CW];
  assign cw_ej_flit    = ej_f[DIR_CW];
  assign ccw_ej_valid  = ej_v[DIR_CCW];
  assign ccw_ej_flit   = ej_f[DIR_CCW];

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_valid <= 1'b0;
      loc_slice <= '0;
      loc_data  <= '0;
    end else begin
      loc_valid <= req_valid && is_local;
      if (req_valid && is_local) begin
        loc_slice <= slice;
        loc_data  <= req_data;
      end
    end
  end
endmodule

// File: rtl/ringstop_chk.sv
module ringstop_chk #(
  parameter int MY_STOP = 2,
  parameter int STOP_W  = 3,
  parameter int FLIT_W  = 23
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cw_in_valid,
  input logic [FLIT_W-1:0] cw_in_flit,
  input logic              cw_out_valid,
  input logic [FLIT_W-1:0] cw_out_flit,
  input logic              ccw_in_valid,
  input logic [FLIT_W-1:0] ccw_in_flit,
  input logic              ccw_out_valid,
  input logic [FLIT_W-1:0] ccw_out_flit,
  input logic              cw_ej_valid,
  input logic [FLIT_W-1:0] cw_ej_flit,
  input logic              ccw_ej_valid,
  input logic              loc_valid
);
  // R5: passing traffic leaves unchanged one hop later
  p_fwd_cw_r5: assert property (@(posedge clk) disable iff (rst)
    (cw_in_valid && cw_in_flit[FLIT_W-1 -: STOP_W] != STOP_W'(MY_STOP))
      |=> (cw_out_valid && cw_out_flit == $past(cw_in_flit)));
  p_fwd_ccw_r5: assert property (@(posedge clk) disable iff (rst)
    (ccw_in_valid && ccw_in_flit[FLIT_W-1 -: STOP_W] != STOP_W'(MY_STOP))
      |=> (ccw_out_valid && ccw_out_flit == $past(ccw_in_flit)));
  // R6: flits for this stop come off the ring
  p_eject_r6: assert property (@(posedge clk) disable iff (rst)
    (cw_in_valid && cw_in_flit[FLIT_W-1 -: STOP_W] == STOP_W'(MY_STOP))
      |=> (cw_ej_valid && cw_ej_flit == $past(cw_in_flit)));
  // R7: an accepted request shows up on exactly one output
  p_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !cw_in_valid && !ccw_in_valid)
      |=> $countones({cw_out_valid, ccw_out_valid, loc_valid}) == 1);
  // R9: reset clears the valids
  p_reset_r9: assert property (@(posedge clk)
    rst |=> !(cw_out_valid || ccw_out_valid || cw_ej_valid || ccw_ej_valid || loc_valid));
endmodule

bind ringstop ringstop_chk #(.MY_STOP(MY_STOP), .STOP_W(STOP_W), .FLIT_W(FLIT_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cw_in_valid(cw_in_valid), .cw_in_flit(cw_in_flit),
  .cw_out_valid(cw_out_valid), .cw_out_flit(cw_out_flit),
  .ccw_in_valid(ccw_in_valid), .ccw_in_flit(ccw_in_flit),
  .ccw_out_valid(ccw_out_valid), .ccw_out_flit(ccw_out_flit),
  .cw_ej_valid(cw_ej_valid), .cw_ej_flit(cw_ej_flit),
  .ccw_ej_valid(ccw_ej_valid), .loc_valid(loc_valid)
);

// File: tb/sim_ringstop.sv
module sim_ringstop;
  logic clk = 0;
  logic rst = 1;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_ready;
  logic [31:0] req_addr = 0;
  logic [15:0] req_data = 0;
  logic        cw_in_valid = 0, ccw_in_valid = 0;
  logic [22:0] cw_in_flit = 0, ccw_in_flit = 0;
  logic        cw_out_valid, ccw_out_valid, cw_ej_valid, ccw_ej_valid, loc_valid;
  logic [22:0] cw_out_flit, ccw_out_flit, cw_ej_flit, ccw_ej_flit;
  logic [3:0]  loc_slice;
  logic [15:0] loc_data;

  ringstop u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mhash(logic [31:0] a);
    int r = 0;
    for (int k = 0; k < 7; k++) r = r ^ int'((a >> (6 + 4 * k)) & 32'hF);
    return r % 12;
  endfunction

  function automatic logic [31:0] addr_for(int s, int skip);
    int n = 0;
    for (int k = 1; k < 4096; k++)
      if (mhash(32'(k) << 6) == s) begin
        if (n == skip) return (32'(k) << 6) | 32'h15;
        n++;
      end
    return 0;
  endfunction

  task automatic step(string tag, logic rv, logic [31:0] a, logic [15:0] d,
                      logic cv, logic [22:0] cf, logic av, logic [22:0] af);
    int s, dst, cwh, ccwh, dir;
    bit local_hit, cpass, apass, rdy, acc;
    @(negedge clk);
    req_valid = rv; req_addr = a; req_data = d;
    cw_in_valid = cv; cw_in_flit = cf; ccw_in_valid = av; ccw_in_flit = af;
    s = mhash(a);
    dst = (s < 6) ? s : 0;
    local_hit = (dst == 2);
    cwh = (dst + 4) % 6; ccwh = (8 - dst) % 6;
    dir = (cwh <= ccwh) ? 0 : 1;
    cpass = cv && (cf[22:20] != 3'd2);
    apass = av && (af[22:20] != 3'd2);
    rdy = local_hit || (dir == 0 ? !cpass : !apass);
    acc = rv && rdy;
    #1 chk({tag, " R7 ready"}, req_ready, rdy);
    @(posedge clk); #1;
    chk({tag, " R5/R7 cw valid"}, cw_out_valid, cpass || (acc && !local_hit && dir == 0));
    if (cpass) chk({tag, " R5 cw flit"}, cw_out_flit, cf);
    else if (acc && !local_hit && dir == 0)
      chk({tag, " R1/R2/R3 cw flit"}, cw_out_flit, {3'(dst), 4'(s), d});
    chk({tag, " R5/R7 ccw valid"}, ccw_out_valid, apass || (acc && !local_hit && dir == 1));
    if (apass) chk({tag, " R5 ccw flit"}, ccw_out_flit, af);
    else if (acc && !local_hit && dir == 1)
      chk({tag, " R1/R2/R3 ccw flit"}, ccw_out_flit, {3'(dst), 4'(s), d});
    chk({tag, " R6 cw ej"}, cw_ej_valid, cv && !cpass);
    if (cv && !cpass) chk({tag, " R6 cw ej flit"}, cw_ej_flit, cf);
    chk({tag, " R6 ccw ej"}, ccw_ej_valid, av && !apass);
    if (av && !apass) chk({tag, " R6 ccw ej flit"}, ccw_ej_flit, af);
    chk({tag, " R4 loc"}, loc_valid, acc && local_hit);
    if (acc && local_hit) chk({tag, " R4 loc data"}, {loc_slice, loc_data}, {4'(s), d});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset", {cw_out_valid, ccw_out_valid, cw_ej_valid, ccw_ej_valid, loc_valid}, 0);
    @(negedge clk); rst = 0;
    step("R3 tie", 1, addr_for(5, 0), 16'h1111, 0, 0, 0, 0);
    step("R3 near cw", 1, addr_for(4, 0), 16'h2222, 0, 0, 0, 0);
    step("R3 ccw", 1, addr_for(1, 0), 16'h3333, 0, 0, 0, 0);
    step("R3 stop0", 1, addr_for(0, 1), 16'h3434, 0, 0, 0, 0);
    step("R2 bridge", 1, addr_for(9, 0), 16'h4444, 0, 0, 0, 0);
    step("R1 hash", 1, 32'hDEADBEEF, 16'h5555, 0, 0, 0, 0);
    step("R4 local", 1, addr_for(2, 0), 16'h6666, 1, {3'd4, 4'd3, 16'hAAAA}, 0, 0);
    step("R7 blocked", 1, addr_for(5, 1), 16'h7777, 1, {3'd1, 4'd1, 16'hBBBB}, 0, 0);
    step("R7 retry", 1, addr_for(5, 1), 16'h7777, 0, 0, 0, 0);
    step("R8 reuse", 1, addr_for(0, 0), 16'h8888, 0, 0, 1, {3'd2, 4'd2, 16'hCCCC});
    step("R6 both", 0, 0, 0, 1, {3'd2, 4'd7, 16'h1234}, 1, {3'd2, 4'd2, 16'h4321});
    for (int i = 0; i < 600; i++)
      step("rand", 1'($urandom), $urandom, 16'($urandom),
           1'($urandom), {3'($urandom % 6), 4'($urandom % 12), 16'($urandom)},
           1'($urandom), {3'($urandom % 6), 4'($urandom % 12), 16'($urandom)});
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    chk("R9 mid reset", {cw_out_valid, ccw_out_valid, cw_ej_valid, ccw_ej_valid, loc_valid}, 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule